// File: doc/BRIEF.md
# VLIW Bundle Instruction Unpacker

This block sits between instruction fetch and issue in a multi-unit cryptographic datapath. Each fetched instruction word is 192 bits wide. The block reads a two-bit format code at the top of the word and splits the rest into per-slot fields for the dispatch stage, with one valid flag per slot. There are four formats. Two of them stand alone: a static configuration word and a super-long word that carries immediates or multi-way branches. The other two share the word with one control slot: four short instructions plus control, or one long instruction plus control. The long instruction drives the wide permutation and wide shift units.

All outputs are registered and appear one clock after the word is presented. Slots that the decoded format does not carry have their valid flag low and their field forced to zero. A word whose reserved field is non-zero is rejected: an illegal flag is raised and every slot stays invalid. The block also reports how many operations the word issues, which is at most five.

Top module: `vliw_unpack`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is zero after that edge, whatever is on the inputs.
- R2: `out_valid` equals `in_valid` from the previous rising edge. When `in_valid` was low, every slot flag, `illegal` and `op_count` are zero and every field is zero.
- R3: Format code `10` in bits [191:190] selects four short slots plus control. Short slot k, with k from 0 to 3, is taken from word bits [179-37k : 143-37k], so slot 0 sits at the top. It appears on `short_data` bits [37k+36 : 37k]. `short_valid` is `1111`, and `ctrl_valid` is set with `ctrl_data` equal to word bits [31:0].
- R4: Format code `11` selects one long slot plus control. `long_data` is word bits [179:32], and `ctrl_data` is word bits [31:0], with `long_valid` and `ctrl_valid` set.
- R5: Format code `00` selects a configuration word. `cfg_data` is word bits [179:0], `cfg_valid` is set, and no other slot is valid.
- R6: Format code `01` selects a super-long word. `xl_data` is word bits [179:0], `xl_valid` is set, and no other slot is valid.
- R7: If a presented word has any of bits [189:180] set, `illegal` is 1 one cycle later, every slot flag is 0, every field is 0 and `op_count` is 0, whatever the format code.
- R8: Every slot that the decoded format does not carry has its valid flag low and its field zero.
- R9: `op_count` is 5 for the short format, 2 for the long format, 1 for the configuration and super-long formats, and 0 for idle or illegal words.
- R10: No more than one of these is active in a cycle: configuration, super-long, any short slot, long slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A word is presented this cycle |
| in_word | input | 192 | Instruction word |
| out_valid | output | 1 | Decoded result present |
| illegal | output | 1 | Reserved field was non-zero |
| cfg_valid | output | 1 | Configuration slot valid |
| cfg_data | output | 180 | Configuration payload |
| xl_valid | output | 1 | Super-long slot valid |
| xl_data | output | 180 | Super-long payload |
| short_valid | output | 4 | Per short slot valid |
| short_data | output | 148 | Four 37-bit short slots, slot k at [37k+36:37k] |
| long_valid | output | 1 | Long slot valid |
| long_data | output | 148 | Long slot |
| ctrl_valid | output | 1 | Control slot valid |
| ctrl_data | output | 32 | Control slot |
| op_count | output | 3 | Operations issued by this word |

## Verification
Two checks can apply to the same word: a legal format code and the rejection of a non-zero reserved field. The bench covers this by setting each reserved bit in turn under every format code, including the shared-control formats, whose slots would otherwise all be valid. It then confirms that the rejection wins: the illegal flag is set, no slot is valid, all fields and the count are zero, and the next word decodes cleanly. The behavioural reference model predicts every output field on every clock, through back-to-back words, idle gaps and a long random mix.

// File: rtl/vbu_pkg.sv
// Package: shared widths, format codes and the slot-select record for the
// bundle unpacker. Assumes a two-bit format code at the top of the word.
package vbu_pkg;
    localparam int FMT_W = 2;

    typedef enum logic [FMT_W-1:0] {
        FMT_CFG  = 2'b00,
        FMT_XL   = 2'b01,
        FMT_QUAD = 2'b10,
        FMT_LONG = 2'b11
    } vbu_fmt_e;

    // One-hot selection of the decoded packing; all zero when idle or illegal.
    typedef struct packed {
        logic cfg;
        logic xl;
        logic quad;
        logic lng;
    } vbu_sel_t;
endpackage

// File: rtl/vbu_fmt_decode.sv
// Format decoder: reads the format code and reserved field of a presented
// word and produces a one-hot packing select plus an illegal indication.
// Assumes the reserved field lies directly below the format code.
module vbu_fmt_decode
    import vbu_pkg::*;
#(
    parameter int WORD_W = 192,
    parameter int RSV_W  = 10
) (
    input  logic              in_valid,
    input  logic [WORD_W-1:0] word,
    output vbu_sel_t          sel,
    output logic              illegal
);
    localparam int FMT_HI = WORD_W - 1;
    localparam int RSV_HI = WORD_W - FMT_W - 1;

    vbu_fmt_e fmt;
    logic     rsv_bad;

    // Extract the format code and test the reserved field.
    always_comb begin
        fmt     = vbu_fmt_e'(word[FMT_HI -: FMT_W]);
        rsv_bad = |word[RSV_HI -: RSV_W];
    end

    // Pick exactly one packing for a legal presented word.
    always_comb begin
        sel     = '0;
        illegal = in_valid && rsv_bad;
        if (in_valid && !rsv_bad) begin
            unique case (fmt)
                FMT_CFG:  sel.cfg  = 1'b1;
                FMT_XL:   sel.xl   = 1'b1;
                FMT_QUAD: sel.quad = 1'b1;
                FMT_LONG: sel.lng  = 1'b1;
                default:  sel      = '0;
            endcase
        end
    end
endmodule

// File: rtl/vbu_slot_split.sv
// Slot splitter: cuts the payload into configuration, super-long, short,
// long and control fields, gating each to zero unless its packing is selected.
// Assumes the short slots together exactly cover the long slot's bit range.
module vbu_slot_split
    import vbu_pkg::*;
#(
    parameter int SHORT_W = 37,
    parameter int N_SHORT = 4,
    parameter int CTRL_W  = 32
) (
    input  logic [N_SHORT*SHORT_W+CTRL_W-1:0] payload,
    input  vbu_sel_t                          sel,
    output logic [N_SHORT*SHORT_W+CTRL_W-1:0] cfg_d,
    output logic [N_SHORT*SHORT_W+CTRL_W-1:0] xl_d,
    output logic [N_SHORT-1:0]                short_v,
    output logic [N_SHORT*SHORT_W-1:0]        short_d,
    output logic                              long_v,
    output logic [N_SHORT*SHORT_W-1:0]        long_d,
    output logic                              ctrl_v,
    output logic [CTRL_W-1:0]                 ctrl_d
);
    localparam int LONG_W = N_SHORT * SHORT_W;

    // Whole-payload slots for the stand-alone packings.
    always_comb begin
        cfg_d = sel.cfg ? payload : '0;
        xl_d  = sel.xl  ? payload : '0;
    end

    // Short slots: slot 0 takes the highest field of the payload.
    for (genvar g = 0; g < N_SHORT; g++) begin : g_short
        localparam int SRC_LO = CTRL_W + (N_SHORT - 1 - g) * SHORT_W;
        always_comb begin
            short_v[g]                      = sel.quad;
            short_d[g*SHORT_W +: SHORT_W]   = sel.quad ? payload[SRC_LO +: SHORT_W] : '0;
        end
    end

    // Long and control slots shared by the two combined packings.
    always_comb begin
        long_v = sel.lng;
        long_d = sel.lng ? payload[CTRL_W +: LONG_W] : '0;
        ctrl_v = sel.quad | sel.lng;
        ctrl_d = (sel.quad | sel.lng) ? payload[CTRL_W-1:0] : '0;
    end
endmodule

// File: rtl/vbu_op_count.sv
// Issue counter: reports how many operations the selected packing issues.
// Assumes a one-hot or all-zero select.
module vbu_op_count
    import vbu_pkg::*;
#(
    parameter int N_SHORT = 4,
    parameter int CNT_W   = 3
) (
    input  vbu_sel_t         sel,
    output logic [CNT_W-1:0] count
);
    // Map each packing to its operation count.
    always_comb begin
        if (sel.quad)               count = CNT_W'(N_SHORT + 1);
        else if (sel.lng)           count = CNT_W'(2);
        else if (sel.cfg || sel.xl) count = CNT_W'(1);
        else                        count = '0;
    end
endmodule

// File: rtl/vliw_unpack.sv
// Bundle unpacker top: decodes a fixed-width instruction word into slot
// fields with valid flags and registers every output once.
// Assumes one word per cycle and no back-pressure from dispatch.
module vliw_unpack
    import vbu_pkg::*;
#(
    parameter int SHORT_W = 37,
    parameter int N_SHORT = 4,
    parameter int CTRL_W  = 32,
    parameter int RSV_W   = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [FMT_W+RSV_W+N_SHORT*SHORT_W+CTRL_W-1:0] in_word,
    output logic                              out_valid,
    output logic                              illegal,
    output logic                              cfg_valid,
    output logic [N_SHORT*SHORT_W+CTRL_W-1:0] cfg_data,
    output logic                              xl_valid,
    output logic [N_SHORT*SHORT_W+CTRL_W-1:0] xl_data,
    output logic [N_SHORT-1:0]                short_valid,
    output logic [N_SHORT*SHORT_W-1:0]        short_data,
    output logic                              long_valid,
    output logic [N_SHORT*SHORT_W-1:0]        long_data,
    output logic                              ctrl_valid,
    output logic [CTRL_W-1:0]                 ctrl_data,
    output logic [$clog2(N_SHORT+2)-1:0]      op_count
);
    localparam int LONG_W = N_SHORT * SHORT_W;
    localparam int PAY_W  = LONG_W + CTRL_W;
    localparam int WORD_W = FMT_W + RSV_W + PAY_W;
    localparam int CNT_W  = $clog2(N_SHORT + 2);

    vbu_sel_t                 sel;
    logic                     ill_c;
    logic [PAY_W-1:0]         cfg_c, xl_c;
    logic [N_SHORT-1:0]       short_v_c;
    logic [LONG_W-1:0]        short_c, long_c;
    logic                     long_v_c, ctrl_v_c;
    logic [CTRL_W-1:0]        ctrl_c;
    logic [CNT_W-1:0]         cnt_c;

    vbu_fmt_decode #(.WORD_W(WORD_W), .RSV_W(RSV_W)) u_dec (
        .in_valid (in_valid),
        .word     (in_word),
        .sel      (sel),
        .illegal  (ill_c)
    );

    vbu_slot_split #(.SHORT_W(SHORT_W), .N_SHORT(N_SHORT), .CTRL_W(CTRL_W)) u_split (
        .payload (in_word[PAY_W-1:0]),
        .sel     (sel),
        .cfg_d   (cfg_c),
        .xl_d    (xl_c),
        .short_v (short_v_c),
        .short_d (short_c),
        .long_v  (long_v_c),
        .long_d  (long_c),
        .ctrl_v  (ctrl_v_c),
        .ctrl_d  (ctrl_c)
    );

    vbu_op_count #(.N_SHORT(N_SHORT), .CNT_W(CNT_W)) u_cnt (
        .sel   (sel),
        .count (cnt_c)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            illegal     <= 1'b0;
            cfg_valid   <= 1'b0;
            cfg_data    <= '0;
            xl_valid    <= 1'b0;
            xl_data     <= '0;
            short_valid <= '0;
            short_data  <= '0;
            long_valid  <= 1'b0;
            long_data   <= '0;
            ctrl_valid  <= 1'b0;
            ctrl_data   <= '0;
            op_count    <= '0;
        end else begin
            out_valid   <= in_valid;
            illegal     <= ill_c;
            cfg_valid   <= sel.cfg;
            cfg_data    <= cfg_c;
            xl_valid    <= sel.xl;
            xl_data     <= xl_c;
            short_valid <= short_v_c;
            short_data  <= short_c;
            long_valid  <= long_v_c;
            long_data   <= long_c;
            ctrl_valid  <= ctrl_v_c;
            ctrl_data   <= ctrl_c;
            op_count    <= cnt_c;
        end
    end
endmodule

// File: rtl/vliw_unpack_chk.sv
// Checker: temporal properties of the bundle unpacker, bound to the top.
module vliw_unpack_chk #(
    parameter int SHORT_W = 37,
    parameter int N_SHORT = 4,
    parameter int CTRL_W  = 32,
    parameter int RSV_W   = 10
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              in_valid,
    input logic [2+RSV_W+N_SHORT*SHORT_W+CTRL_W-1:0] in_word,
    input logic                              out_valid,
    input logic                              illegal,
    input logic                              cfg_valid,
    input logic [N_SHORT*SHORT_W+CTRL_W-1:0] cfg_data,
    input logic                              xl_valid,
    input logic [N_SHORT*SHORT_W+CTRL_W-1:0] xl_data,
    input logic [N_SHORT-1:0]                short_valid,
    input logic [N_SHORT*SHORT_W-1:0]        short_data,
    input logic                              long_valid,
    input logic [N_SHORT*SHORT_W-1:0]        long_data,
    input logic                              ctrl_valid,
    input logic [CTRL_W-1:0]                 ctrl_data,
    input logic [$clog2(N_SHORT+2)-1:0]      op_count
);
    localparam int WORD_W = 2 + RSV_W + N_SHORT * SHORT_W + CTRL_W;

    p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && op_count == '0 && !ctrl_valid && ctrl_data == '0));

    p_quad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[WORD_W-1 -: 2] == 2'b10 && in_word[WORD_W-3 -: RSV_W] == '0)
        |=> (&short_valid && ctrl_valid));

    p_ctrl_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (long_valid || |short_valid) |-> ctrl_valid);

    p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[WORD_W-3 -: RSV_W] != '0) |=>
        (illegal && op_count == '0 && !cfg_valid && !xl_valid && short_valid == '0
         && !long_valid && !ctrl_valid));

    p_absent_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_valid |-> cfg_data == '0) and (!xl_valid |-> xl_data == '0)
        and (!long_valid |-> long_data == '0) and (!ctrl_valid |-> ctrl_data == '0));

    p_five_ops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|short_valid) |-> op_count == 3'($countones(short_valid) + 1));

    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_valid, xl_valid, |short_valid, long_valid}));
endmodule

bind vliw_unpack vliw_unpack_chk #(
    .SHORT_W(SHORT_W), .N_SHORT(N_SHORT), .CTRL_W(CTRL_W), .RSV_W(RSV_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .illegal(illegal), .cfg_valid(cfg_valid),
    .cfg_data(cfg_data), .xl_valid(xl_valid), .xl_data(xl_data),
    .short_valid(short_valid), .short_data(short_data), .long_valid(long_valid),
    .long_data(long_data), .ctrl_valid(ctrl_valid), .ctrl_data(ctrl_data),
    .op_count(op_count)
);

// File: tb/vliw_unpack_tb_top.sv
// Bench: behavioural reference model compared on every clock.
module vliw_unpack_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [191:0] in_word = '0;
    logic         out_valid, illegal, cfg_valid, xl_valid, long_valid, ctrl_valid;
    logic [179:0] cfg_data, xl_data;
    logic [3:0]   short_valid;
    logic [147:0] short_data, long_data;
    logic [31:0]  ctrl_data;
    logic [2:0]   op_count;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;
    logic         pv = 1'b0;
    logic [191:0] pw = '0;

    always #5 clk = ~clk;

    vliw_unpack dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .illegal(illegal), .cfg_valid(cfg_valid),
        .cfg_data(cfg_data), .xl_valid(xl_valid), .xl_data(xl_data),
        .short_valid(short_valid), .short_data(short_data), .long_valid(long_valid),
        .long_data(long_data), .ctrl_valid(ctrl_valid), .ctrl_data(ctrl_data),
        .op_count(op_count)
    );

    task automatic cmp(string req, string what, logic [191:0] act, logic [191:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [191:0] rnd192();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    // Reference model: expected outputs for the word presented one edge earlier.
    task automatic check_prev();
        bit           ok = pv && (pw[189:180] == 10'd0);
        logic [1:0]   f = pw[191:190];
        bit           q = ok && f == 2'b10;
        bit           l = ok && f == 2'b11;
        bit           c = ok && f == 2'b00;
        bit           x = ok && f == 2'b01;
        logic [147:0] es = '0;
        int           n;
        for (int k = 0; k < 4; k++)
            if (q) es[k*37 +: 37] = 37'(pw >> (32 + 37 * (3 - k)));
        n = q ? 5 : l ? 2 : (c || x) ? 1 : 0;
        cmp("R2", "out_valid", 192'(out_valid), 192'(pv));
        cmp("R7", "illegal", 192'(illegal), 192'(pv && !ok));
        cmp(c ? "R5" : "R8", "cfg_valid", 192'(cfg_valid), 192'(c));
        cmp(c ? "R5" : "R8", "cfg_data", 192'(cfg_data), c ? 192'(pw[179:0]) : '0);
        cmp(x ? "R6" : "R8", "xl_valid", 192'(xl_valid), 192'(x));
        cmp(x ? "R6" : "R8", "xl_data", 192'(xl_data), x ? 192'(pw[179:0]) : '0);
        cmp(q ? "R3" : "R8", "short_valid", 192'(short_valid), q ? 192'hF : '0);
        cmp(q ? "R3" : "R8", "short_data", 192'(short_data), 192'(es));
        cmp(l ? "R4" : "R8", "long_valid", 192'(long_valid), 192'(l));
        cmp(l ? "R4" : "R8", "long_data", 192'(long_data), l ? 192'(pw[179:32]) : '0);
        cmp((q || l) ? "R4" : "R8", "ctrl", 192'({ctrl_valid, ctrl_data}),
            (q || l) ? 192'({1'b1, pw[31:0]}) : '0);
        cmp("R9", "op_count", 192'(op_count), 192'(n));
        cmp("R10", "exclusive", 192'($countones({cfg_valid, xl_valid, |short_valid, long_valid}) <= 1), 192'(1));
    endtask

    task automatic step(logic v, logic [191:0] w);
        @(negedge clk);
        check_prev();
        in_valid = v;
        in_word  = w;
        pv = v;
        pw = w;
    endtask

    function automatic logic [191:0] mk(logic [1:0] f, logic [179:0] p);
        return {f, 10'd0, p};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog act=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs zero while a legal word is presented.
        in_valid = 1'b1;
        in_word  = mk(2'b10, '1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            cmp("R1", "reset outs", 192'({out_valid, cfg_valid, xl_valid, short_valid, long_valid,
                ctrl_valid, illegal, op_count}), '0);
            cmp("R1", "reset data", 192'(short_data ^ long_data ^ 148'(ctrl_data)), '0);
            cmp("R1", "reset wide", 192'(cfg_data | xl_data), '0);
        end
        in_valid = 1'b0;
        in_word  = '0;
        @(negedge clk);
        rst_n = 1'b1;
        // R3..R6: each format with fixed and random payloads, back to back.
        for (int f = 0; f < 4; f++) begin
            step(1'b1, mk(2'(f), '1));
            step(1'b1, mk(2'(f), {45{4'h5}}));
            step(1'b1, mk(2'(f), '0));
            step(1'b1, mk(2'(f), 180'(rnd192())));
            step(1'b0, rnd192());
        end
        // R3 slot order: distinct tag per short slot.
        step(1'b1, mk(2'b10, {37'h11_1111_1111, 37'h02_2222_2222, 37'h13_3333_3333,
                              37'h04_4444_4444, 32'hCAFE_F00D}));
        // R7: each reserved bit under each format code, then a clean word.
        for (int b = 0; b < 10; b++)
            for (int f = 0; f < 4; f++) begin
                logic [191:0] w = mk(2'(f), 180'(rnd192()));
                w[180 + b] = 1'b1;
                step(1'b1, w);
            end
        step(1'b1, mk(2'b11, 180'(rnd192())));
        // R2/R8: idle cycles with garbage on the word.
        for (int i = 0; i < 4; i++) step(1'b0, rnd192());
        // Random mix of formats, idles and reserved-field hits.
        for (int i = 0; i < 300; i++) begin
            logic [191:0] w = rnd192();
            if (($urandom % 4) != 0) w[189:180] = '0;
            step(($urandom % 5) != 0, w);
        end
        step(1'b0, '0);
        step(1'b0, '0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule